// File: doc/BRIEF.md
# I2C Slave Masked Address Matcher

This block handles the address phase of an I2C slave whose own address can be widened by a five-bit mask. It watches the already-synchronized SCL and SDA lines, detects START, repeated START and STOP, and shifts in one address byte in 7-bit mode or two in 10-bit mode. It compares them with a stored own address, treating every masked bit as don't-care. On a match it pulls SDA low for the acknowledge clock and raises a one-cycle match pulse. It also exposes the byte actually received, so the surrounding logic can tell which of the acknowledged addresses was used.

The mask maps differently in the two modes. In 7-bit mode each mask bit covers one address bit, bits 5 to 1. In 10-bit mode the top four mask bits cover low-byte bits 5 to 2, and the lowest mask bit covers both bits 1 and 0. The two high address bits sent in the first 10-bit byte are never masked. Data transfer after the address, clock stretching and the general-call address are handled elsewhere.

Top module: `i2c_addr_mask_match`

## Requirements
- R1: A START (SDA falls while SCL is high) begins a new address reception from any state, including a repeated START with no STOP before it. A STOP (SDA rises while SCL is high) abandons any reception, and nothing is acknowledged until the next START.
- R2: Address bits are sampled on SCL rising edges, MSB first. In 7-bit mode received bits 7:1 are compared with `cfg_own_addr[7:1]`, and received bit 0 (the R/W bit) never affects the result.
- R3: In 7-bit mode `cfg_mask[k-1]` = 1 (k = 1..5) makes address bit k don't-care. With own address A0h and mask 00111, bytes A0h, A2h, A4h, A6h, A8h, AAh, ACh and AEh are acknowledged (either R/W value), and no others.
- R4: In 10-bit mode (`cfg_ten_bit` = 1) the first byte must be 11110 in bits 7:3 and `cfg_own_hi` in bits 2:1, exactly and with no masking. Bit 0 is R/W. A matching first byte is acknowledged and the block then receives a second byte.
- R5: In 10-bit mode the second byte is compared with `cfg_own_addr[7:0]`. `cfg_mask[4:1]` makes bits 5:2 don't-care, `cfg_mask[0]` makes both bits 1 and 0 don't-care, and bits 7:6 are always compared. With A0h and mask 00111 the bytes A0h through AFh are acknowledged.
- R6: On a match, `sda_pull_o` rises at the first clock that sees SCL low after the 8th bit. It stays high through the 9th SCL high phase and falls at the first clock that sees SCL low again.
- R7: `match_o` is high for exactly one clock, at the first clock that sees the 8th SCL rise of the final address byte (the only byte in 7-bit mode, the second in 10-bit mode), and only when that byte matches. A 10-bit first byte never raises it.
- R8: `rx_addr_o` loads each complete address byte, R/W position included, at the first clock that sees its 8th SCL rise, and holds it otherwise.
- R9: After a mismatch the block gives no acknowledge and no pulse, and it ignores all bits until the next START.
- R10: With `cfg_mask` all zero, only the exact own address is acknowledged. With the mask in use, the acknowledge and pulse timing is the same as without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level (wired bus value) |
| cfg_ten_bit | input | 1 | 1 selects 10-bit addressing |
| cfg_own_addr | input | 8 | Own address: bits 7:1 in 7-bit mode, low byte in 10-bit mode |
| cfg_own_hi | input | 2 | Own address bits 9:8 for 10-bit mode |
| cfg_mask | input | 5 | Address mask; bit k-1 corresponds to mask position k |
| sda_pull_o | output | 1 | 1 pulls SDA low (acknowledge) |
| match_o | output | 1 | One-cycle pulse on a completed address match |
| rx_addr_o | output | 8 | Last complete address byte received |

## Verification
Every output is registered behind one stage of edge detection, so each result falls due at the first rising clock edge after the bench changes SCL or SDA. The bench changes the bus on falling clock edges and sets its expected values right after the rising edge that should produce the change. The reference model compares `sda_pull_o` and `match_o` with these values at every falling edge, so an acknowledge or pulse that arrives one clock early or late, or lasts one clock too long, is reported. `rx_addr_o` is checked once the acknowledge clock has ended, and the acknowledge level on the wired bus is checked mid-way through the 9th SCL high phase.

// File: rtl/i2c_am_pkg.sv
// Package: shared constants and state type for the masked address matcher.
// Assumes 8-bit address bytes as on any I2C bus.
package i2c_am_pkg;
    localparam int          BYTE_W     = 8;
    localparam int          MASK_W     = 5;
    localparam logic [4:0]  TEN_PREFIX = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for START
        ST_ADDR,    // shifting address bits
        ST_ACKW,    // matched, waiting for SCL low to drive ACK
        ST_ACK,     // driving ACK through ninth clock
        ST_DONE,    // address phase finished, wait for START/STOP
        ST_IGNORE   // mismatch, wait for START
    } am_state_t;
endpackage

// File: rtl/i2c_bus_edges.sv
// Bus event detector: registers the previous SCL/SDA levels and flags
// START, STOP and SCL edges for the current clock.
// Assumes scl_i/sda_i are already synchronized to clk.
module i2c_bus_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic ev_start,
    output logic ev_stop,
    output logic ev_rise,
    output logic ev_fall
);
    logic scl_q;
    logic sda_q;

    // Keep last seen bus levels; idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Decode bus conditions from the old and new levels.
    always_comb begin
        ev_start = scl_q & scl_i & sda_q & ~sda_i;
        ev_stop  = scl_q & scl_i & ~sda_q & sda_i;
        ev_rise  = ~scl_q & scl_i;
        ev_fall  = scl_q & ~scl_i;
    end
endmodule

// File: rtl/addr_mask_cmp.sv
// Masked address comparator: decides whether a received byte matches the
// own address in 7-bit mode, the 10-bit first byte, or the 10-bit low byte.
// Assumes BYTE_W = 8 and MASK_W <= BYTE_W - 2.
module addr_mask_cmp #(
    parameter int BYTE_W = 8,
    parameter int MASK_W = 5
) (
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [BYTE_W-1:0] own_addr,
    input  logic [1:0]        own_hi,
    input  logic [MASK_W-1:0] mask,
    input  logic              ten_bit,
    input  logic              second,
    output logic              hit
);
    import i2c_am_pkg::*;

    logic [BYTE_W-1:0] care_seven;
    logic [BYTE_W-1:0] care_ten;

    // Build per-bit "must compare" vectors for both mask mappings.
    for (genvar g = 0; g < BYTE_W; g++) begin : g_care
        if (g == 0) begin : g_b0
            assign care_seven[g] = 1'b0;         // R/W position
            assign care_ten[g]   = ~mask[0];     // shares mask bit 1
        end else if (g <= MASK_W) begin : g_mid
            assign care_seven[g] = ~mask[g-1];
            if (g == 1) begin : g_b1
                assign care_ten[g] = ~mask[0];
            end else begin : g_bn
                assign care_ten[g] = ~mask[g-1];
            end
        end else begin : g_top
            assign care_seven[g] = 1'b1;
            assign care_ten[g]   = 1'b1;
        end
    end

    logic hit_seven;
    logic hit_first;
    logic hit_low;

    // Select the comparison that applies to the current byte.
    always_comb begin
        hit_seven = ((rx_byte ^ own_addr) & care_seven) == '0;
        hit_first = (rx_byte[7:3] == TEN_PREFIX) && (rx_byte[2:1] == own_hi);
        hit_low   = ((rx_byte ^ own_addr) & care_ten) == '0;
        if (!ten_bit)    hit = hit_seven;
        else if (second) hit = hit_low;
        else             hit = hit_first;
    end
endmodule

// File: rtl/i2c_addr_mask_match.sv
// Address phase of an I2C slave with a maskable own address.
// Detects START/STOP, shifts address bytes on SCL rise, compares under the
// mask, drives ACK in the ninth clock and pulses match_o on a full match.
// Assumes synchronized inputs and an open-drain pad driven by sda_pull_o.
module i2c_addr_mask_match
    import i2c_am_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              cfg_ten_bit,
    input  logic [BYTE_W-1:0] cfg_own_addr,
    input  logic [1:0]        cfg_own_hi,
    input  logic [MASK_W-1:0] cfg_mask,
    output logic              sda_pull_o,
    output logic              match_o,
    output logic [BYTE_W-1:0] rx_addr_o
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic ev_start, ev_stop, ev_rise, ev_fall;

    i2c_bus_edges u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .ev_start (ev_start),
        .ev_stop  (ev_stop),
        .ev_rise  (ev_rise),
        .ev_fall  (ev_fall)
    );

    am_state_t         state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              second;
    logic [BYTE_W-1:0] byte_now;
    logic              hit;
    logic              last_byte;

    // Byte as it stands once the current bit is shifted in.
    always_comb begin
        byte_now  = {shreg[BYTE_W-2:0], sda_i};
        last_byte = !cfg_ten_bit || second;
    end

    addr_mask_cmp #(.BYTE_W(BYTE_W), .MASK_W(MASK_W)) u_cmp (
        .rx_byte  (byte_now),
        .own_addr (cfg_own_addr),
        .own_hi   (cfg_own_hi),
        .mask     (cfg_mask),
        .ten_bit  (cfg_ten_bit),
        .second   (second),
        .hit      (hit)
    );

    // Address-phase sequencer: shift, compare, acknowledge, pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            second     <= 1'b0;
            sda_pull_o <= 1'b0;
            match_o    <= 1'b0;
            rx_addr_o  <= '0;
        end else begin
            match_o <= 1'b0;
            if (ev_start) begin
                state      <= ST_ADDR;
                bit_cnt    <= '0;
                second     <= 1'b0;
                sda_pull_o <= 1'b0;
            end else if (ev_stop) begin
                state      <= ST_IDLE;
                sda_pull_o <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: if (ev_rise) begin
                        shreg <= byte_now;
                        if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                            bit_cnt   <= '0;
                            rx_addr_o <= byte_now;
                            if (hit) begin
                                state   <= ST_ACKW;
                                match_o <= last_byte;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    ST_ACKW: if (ev_fall) begin
                        sda_pull_o <= 1'b1;
                        state      <= ST_ACK;
                    end
                    ST_ACK: if (ev_fall) begin
                        sda_pull_o <= 1'b0;
                        if (!last_byte) begin
                            second <= 1'b1;
                            state  <= ST_ADDR;
                        end else begin
                            state <= ST_DONE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R6: ACK only starts and ends while SCL is low.
    a_r6_pull_starts_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_i);
    a_r6_pull_ends_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull_o) |-> !scl_i);
    // R7: match pulse lasts one clock and is followed by an ACK.
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> !match_o);
    a_r7_pulse_then_ack: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> state == ST_ACKW);
    // R9: a rejected address never drives the bus.
    a_r9_ignore_silent: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IGNORE |-> !sda_pull_o);
    // R1: START always releases the bus.
    a_r1_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> !sda_pull_o);
endmodule

// File: tb/sim_i2c_addr_mask_match.sv
module sim_i2c_addr_mask_match;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       ten = 1'b0;
    logic [7:0] own = 8'hA0;
    logic [1:0] own_hi = 2'b00;
    logic [4:0] mask = 5'b00000;
    logic       sda_pull;
    logic       match;
    logic [7:0] rx_addr;
    logic       sda_bus;

    int    checks = 0;
    int    fails = 0;
    bit    exp_ack = 1'b0;
    bit    exp_pulse = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    assign sda_bus = m_sda & ~sda_pull;

    always #(CLK_P/2) clk = ~clk;

    i2c_addr_mask_match u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl),
        .sda_i        (sda_bus),
        .cfg_ten_bit  (ten),
        .cfg_own_addr (own),
        .cfg_own_hi   (own_hi),
        .cfg_mask     (mask),
        .sda_pull_o   (sda_pull),
        .match_o      (match),
        .rx_addr_o    (rx_addr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Cycle-by-cycle reference comparison of ACK (R6) and pulse (R7).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(sda_pull == exp_ack, {cur_req, " R6 ack"}, sda_pull, exp_ack);
            check(match == exp_pulse, {cur_req, " R7 pulse"}, match, exp_pulse);
        end
    end

    // Reference address rules, written per bit from the requirements.
    function automatic bit ref7(input logic [7:0] b, input logic [7:0] o, input logic [4:0] m);
        for (int i = 1; i < 8; i++) begin
            if (i <= 5 && m[i-1]) continue;
            if (b[i] != o[i]) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic bit ref10lo(input logic [7:0] b, input logic [7:0] o, input logic [4:0] m);
        for (int i = 0; i < 8; i++) begin
            if (i <= 1 && m[0]) continue;
            if (i >= 2 && i <= 5 && m[i-1]) continue;
            if (b[i] != o[i]) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(1);
        scl = 1'b1;   tick(2);
        m_sda = 1'b0; tick(3);
        scl = 1'b0;   tick(2);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(2);
        scl = 1'b1;   tick(2);
        m_sda = 1'b1; tick(2);
    endtask

    task automatic send_bit(input logic b, input bit last, input bit ack_e, input bit pulse_e);
        m_sda = b; tick(2);
        scl = 1'b1;
        if (last) begin
            @(posedge clk); exp_pulse = pulse_e;
            @(posedge clk); exp_pulse = 1'b0;
            tick(3);
        end else begin
            tick(4);
        end
        scl = 1'b0;
        if (last) begin
            @(posedge clk); exp_ack = ack_e;
        end
        tick(2);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit ack_e, input bit pulse_e,
                             input bit chk_rx, input string req);
        cur_req = req;
        for (int i = 7; i >= 0; i--) send_bit(b[i], i == 0, ack_e, pulse_e);
        m_sda = 1'b1; tick(2);
        scl = 1'b1;   tick(2);
        check(sda_bus == !ack_e, {req, " R6 bus ack"}, sda_bus, !ack_e);
        tick(2);
        scl = 1'b0;
        @(posedge clk); exp_ack = 1'b0;
        tick(2);
        if (chk_rx) check(rx_addr == b, {req, " R8 rx_addr"}, rx_addr, b);
    endtask

    task automatic seven_sweep(input logic [4:0] m, input string req);
        mask = m;
        for (int a = 0; a < 256; a += 3) begin
            logic [7:0] b = 8'(a);
            bit e = ref7(b, own, m);
            bus_start();
            send_byte(b, e, e, 1'b1, req);
            bus_stop();
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        tick(5);
        check(sda_pull == 1'b0, "R1 reset pull", sda_pull, 0);
        check(match == 1'b0, "R1 reset match", match, 0);
        check(rx_addr == 8'h00, "R8 reset rx", rx_addr, 0);
        rst_n = 1'b1;
        tick(3);

        // R10 / R2: exact compare, R/W bit ignored.
        own = 8'hA0; mask = 5'b00000; ten = 1'b0;
        bus_start(); send_byte(8'hA0, 1, 1, 1, "R10"); bus_stop();
        bus_start(); send_byte(8'hA1, 1, 1, 1, "R2");  bus_stop();
        bus_start(); send_byte(8'hA2, 0, 0, 1, "R10"); bus_stop();

        // R3: worked mask case and other masks, swept across addresses.
        mask = 5'b00111;
        for (int k = 0; k < 8; k++) begin
            bus_start(); send_byte(8'(8'hA0 + 2*k), 1, 1, 1, "R3"); bus_stop();
        end
        bus_start(); send_byte(8'hB0, 0, 0, 1, "R3"); bus_stop();
        seven_sweep(5'b00111, "R3");
        seven_sweep(5'b11111, "R3");
        own = 8'h5A;
        seven_sweep(5'b10101, "R3");
        seven_sweep(5'b00000, "R10");

        // R9: mismatch, then bits ignored without START, then repeated START.
        own = 8'hA0; mask = 5'b00000;
        bus_start(); send_byte(8'hA4, 0, 0, 1, "R9");
        send_byte(8'hA0, 0, 0, 0, "R9");
        bus_start(); send_byte(8'hA0, 1, 1, 1, "R1"); bus_stop();

        // R1: STOP mid-byte abandons reception.
        bus_start();
        cur_req = "R1";
        for (int i = 0; i < 4; i++) send_bit(1'b1, 0, 0, 0);
        bus_stop();
        send_byte(8'hA0, 0, 0, 0, "R1");
        // Repeated START right after an acknowledged address.
        bus_start(); send_byte(8'hA0, 1, 1, 1, "R1");
        bus_start(); send_byte(8'hA3, 0, 0, 1, "R1"); bus_stop();

        // R4 / R5: 10-bit addressing, worked case then sweep.
        ten = 1'b1; own = 8'hA0; own_hi = 2'b01; mask = 5'b00111;
        bus_start(); send_byte(8'b11110_01_0, 1, 0, 1, "R4");
        send_byte(8'hAF, 1, 1, 1, "R5"); bus_stop();
        bus_start(); send_byte(8'b11110_10_0, 0, 0, 1, "R4");
        send_byte(8'hA0, 0, 0, 0, "R4"); bus_stop();
        bus_start(); send_byte(8'b11100_01_0, 0, 0, 1, "R4"); bus_stop();
        for (int a = 0; a < 256; a++) begin
            logic [7:0] b = 8'(a);
            bit e = ref10lo(b, own, mask);
            bus_start(); send_byte(8'b11110_01_0, 1, 0, 1, "R4");
            send_byte(b, e, e, 1, "R5"); bus_stop();
        end
        mask = 5'b00001;
        for (int a = 8'h9C; a < 8'hA8; a++) begin
            logic [7:0] b = 8'(a);
            bit e = ref10lo(b, own, mask);
            bus_start(); send_byte(8'b11110_01_1, 1, 0, 1, "R4");
            send_byte(b, e, e, 1, "R5"); bus_stop();
        end
        mask = 5'b11110;
        for (int a = 0; a < 256; a += 5) begin
            logic [7:0] b = 8'(a);
            bit e = ref10lo(b, own, mask);
            bus_start(); send_byte(8'b11110_01_0, 1, 0, 1, "R4");
            send_byte(b, e, e, 1, "R5"); bus_stop();
        end

        tick(4);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule